// File: doc/BRIEF.md
# Shared Transmit Packet Buffer Slot Manager

This block owns a transmit packet store that several requesters share. A requester asks for a slot and says whether its packet carries a payload. If it does, the requester also gives the payload length in bytes. The block keeps two separate pools of slots: one for packets with a payload and one for packets without. It grants a free slot of the right class and returns the slot index. The requester places that index in its outgoing DMA read request.

DMA response beats come back tagged with the slot index. They may be interleaved across slots. Each beat is 128 bits, and the block writes it into the slot's region of a two-port memory. The block counts the beats that have arrived for each slot. When a slot has received all its beats, the slot joins a forwarding queue in completion order. The queue offers one slot at a time to a downstream transmit FIFO. The FIFO reads the beats through the memory's read port and accepts the slot with a valid/ready handshake. On acceptance the slot goes back to its free pool.

With default parameters the store is 4.5 KB:
- 16 payload slots of 16 beats (256 bytes) each.
- 16 no-payload slots of 2 beats each, for a 32-byte header/control record.

Top module: `sbm_top`

## Requirements
- R1: After reset, `gnt_valid` and `fwd_valid` are low and every slot of both classes is free.
- R2: Payload slots are numbered 0..15 and no-payload slots 16..31. A grant always hands out the lowest-numbered free slot of the class the winning requester asked for (`req_nopay` = 1 selects the no-payload class).
- R3: At most one grant is made per cycle. A request seen at a clock edge is answered by `gnt_valid`, `gnt_req` and `gnt_slot` registered at that edge. Requesters are served round-robin, starting after the last winner, with requester 0 first after reset. The requester granted in the previous cycle is skipped for one cycle, so a held request is not granted twice.
- R4: A request whose class has no free slot stays pending without a grant. Requests for the other class are still granted meanwhile.
- R5: A payload slot needs ceil(`req_len`/16) beats and a no-payload slot needs 2 beats. `fwd_beats` reports that count for the offered slot. A slot is never offered before its last beat has been written.
- R6: Beats for different slots may interleave. Each slot counts its own beats, and the k-th beat of slot s is stored at word s*16+k for a payload slot and at word 256+(s-16)*2+k for a no-payload slot.
- R7: Slots are offered on `fwd_slot` in the order in which their last beats arrived. While `fwd_ready` is low, `fwd_valid` and `fwd_slot` hold steady.
- R8: The slot offered with `fwd_valid` and `fwd_ready` both high is freed at that edge. A request seen at the next edge can be granted that slot.
- R9: `rd_en` with `rd_slot` and `rd_beat` returns the stored beat on `rd_data` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Per-requester slot request |
| req_nopay | input | 4 | Per-requester class: 1 = no payload |
| req_len | input | 36 | Per-requester payload length, 9 bits each (1..256) |
| gnt_valid | output | 1 | A grant was made |
| gnt_req | output | 2 | Index of the granted requester |
| gnt_slot | output | 5 | Granted slot index |
| rsp_valid | input | 1 | DMA response beat present |
| rsp_slot | input | 5 | Slot the beat belongs to |
| rsp_data | input | 128 | Beat data |
| fwd_valid | output | 1 | A filled slot is offered |
| fwd_slot | output | 5 | Offered slot index |
| fwd_beats | output | 5 | Beat count of the offered slot |
| fwd_ready | input | 1 | Transmit FIFO accepts the offered slot |
| rd_en | input | 1 | Read request to the store |
| rd_slot | input | 5 | Slot to read |
| rd_beat | input | 4 | Beat within the slot |
| rd_data | output | 128 | Read data, one cycle after `rd_en` |

## Verification
Two events can land on the same clock edge:
- A forward acceptance frees a slot while another request for that same class is being arbitrated.
- A final beat enqueues a slot while the FIFO is taking the queue head.

The bench provokes the first directly. It exhausts the no-payload pool, leaves one request pending, and then accepts a filled no-payload slot. It checks that no grant occurs at the release edge and that the freed index is granted at the next edge. The random phase keeps `fwd_ready` toggling while interleaved beats finish slots. A cycle model of the free pools, per-slot counts and completion queue judges every grant, offer, beat count and read-back.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic {
    CLS_PAYLOAD = 1'b0,
    CLS_NOPAY   = 1'b1
  } slot_class_e;

  function automatic int ceil_div(int num, int den);
    return (num + den - 1) / den;
  endfunction

  // word address of beat 0 of a slot; payload slots first, then the small slots
  function automatic int slot_base(int slot, int n_pay, int pay_beats, int np_beats);
    if (slot < n_pay) return slot * pay_beats;
    return n_pay * pay_beats + (slot - n_pay) * np_beats;
  endfunction

endpackage

// File: rtl/sbm_slot_alloc.sv
module sbm_slot_alloc #(
  parameter int NUM_REQ    = 4,
  parameter int NUM_PS     = 16,
  parameter int NUM_NS     = 16,
  parameter int LEN_W      = 9,
  parameter int BEAT_BYTES = 16,
  parameter int NP_BEATS   = 2,
  parameter int BCNT_W     = 5,
  localparam int NUM_SLOTS = NUM_PS + NUM_NS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int REQ_W     = $clog2(NUM_REQ)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ-1:0]       req_nopay,
  input  logic [NUM_REQ*LEN_W-1:0] req_len,
  input  logic                     rel_valid,
  input  logic [SLOT_W-1:0]        rel_slot,
  output logic                     set_valid,
  output logic [SLOT_W-1:0]        set_slot,
  output logic [BCNT_W-1:0]        set_beats,
  output logic                     gnt_valid,
  output logic [REQ_W-1:0]         gnt_req,
  output logic [SLOT_W-1:0]        gnt_slot
);
  import sbm_pkg::*;

  logic [NUM_PS-1:0]  p_busy;
  logic [NUM_NS-1:0]  n_busy;
  logic [SLOT_W-1:0]  p_pick, n_pick;
  logic [NUM_REQ-1:0] elig;
  logic [REQ_W-1:0]   rr_last, win;
  logic               win_found;
  slot_class_e        win_cls;
  logic [LEN_W-1:0]   win_len;

  always_comb begin
    p_pick = '0;
    for (int i = NUM_PS - 1; i >= 0; i--)
      if (!p_busy[i]) p_pick = SLOT_W'(i);
    n_pick = '0;
    for (int i = NUM_NS - 1; i >= 0; i--)
      if (!n_busy[i]) n_pick = SLOT_W'(NUM_PS + i);
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++)
      elig[i] = req_valid[i] && !(gnt_valid && gnt_req == REQ_W'(i)) &&
                (req_nopay[i] ? !(&n_busy) : !(&p_busy));
    win_found = 1'b0;
    win       = '0;
    for (int k = 1; k <= NUM_REQ; k++)
      if (!win_found && elig[(int'(rr_last) + k) % NUM_REQ]) begin
        win_found = 1'b1;
        win       = REQ_W'((int'(rr_last) + k) % NUM_REQ);
      end
    win_cls = req_nopay[win] ? CLS_NOPAY : CLS_PAYLOAD;
    win_len = req_len[int'(win)*LEN_W +: LEN_W];
  end

  assign set_valid = win_found;
  assign set_slot  = (win_cls == CLS_NOPAY) ? n_pick : p_pick;
  assign set_beats = (win_cls == CLS_NOPAY) ? BCNT_W'(NP_BEATS)
                                            : BCNT_W'(ceil_div(int'(win_len), BEAT_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_busy    <= '0;
      n_busy    <= '0;
      gnt_valid <= 1'b0;
      gnt_req   <= '0;
      gnt_slot  <= '0;
      rr_last   <= REQ_W'(NUM_REQ - 1);
    end else begin
      gnt_valid <= win_found;
      if (win_found) begin
        gnt_req  <= win;
        gnt_slot <= set_slot;
        rr_last  <= win;
      end
      for (int i = 0; i < NUM_PS; i++) begin
        if (rel_valid && rel_slot == SLOT_W'(i)) p_busy[i] <= 1'b0;
        if (win_found && win_cls == CLS_PAYLOAD && p_pick == SLOT_W'(i)) p_busy[i] <= 1'b1;
      end
      for (int i = 0; i < NUM_NS; i++) begin
        if (rel_valid && rel_slot == SLOT_W'(NUM_PS + i)) n_busy[i] <= 1'b0;
        if (win_found && win_cls == CLS_NOPAY && n_pick == SLOT_W'(NUM_PS + i)) n_busy[i] <= 1'b1;
      end
    end
  end

  // R3
  gnt_had_req_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (($past(req_valid) & (NUM_REQ'(1) << gnt_req)) != '0));

  // R2
  gnt_class_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ((gnt_slot >= SLOT_W'(NUM_PS)) ==
                   (($past(req_nopay) & (NUM_REQ'(1) << gnt_req)) != '0)));

  // R8
  rel_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_slot < SLOT_W'(NUM_PS) ? p_busy[rel_slot[$clog2(NUM_PS)-1:0]]
                                              : n_busy[(rel_slot - SLOT_W'(NUM_PS))]));
endmodule

// File: rtl/sbm_fill_track.sv
module sbm_fill_track #(
  parameter int NUM_PS    = 16,
  parameter int NUM_NS    = 16,
  parameter int PAY_BEATS = 16,
  parameter int NP_BEATS  = 2,
  parameter int BCNT_W    = 5,
  parameter int ADDR_W    = 9,
  localparam int NUM_SLOTS = NUM_PS + NUM_NS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_valid,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [BCNT_W-1:0] set_beats,
  input  logic              rsp_valid,
  input  logic [SLOT_W-1:0] rsp_slot,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  input  logic [SLOT_W-1:0] q_slot,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done_valid,
  output logic [SLOT_W-1:0] done_slot,
  output logic              q_filled,
  output logic [BCNT_W-1:0] q_beats
);
  logic [BCNT_W-1:0] need_q [NUM_SLOTS];
  logic [BCNT_W-1:0] got_q  [NUM_SLOTS];
  logic [BCNT_W-1:0] got_nxt;

  assign got_nxt    = got_q[rsp_slot] + BCNT_W'(1);
  assign wr_en      = rsp_valid;
  assign wr_addr    = ADDR_W'(sbm_pkg::slot_base(int'(rsp_slot), NUM_PS, PAY_BEATS, NP_BEATS)
                              + int'(got_q[rsp_slot]));
  assign done_valid = rsp_valid && (got_nxt == need_q[rsp_slot]);
  assign done_slot  = rsp_slot;
  assign q_filled   = (got_q[q_slot] == need_q[q_slot]);
  assign q_beats    = need_q[q_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        need_q[i] <= '0;
        got_q[i]  <= '0;
      end
    end else begin
      if (set_valid) need_q[set_slot] <= set_beats;
      if (rsp_valid) got_q[rsp_slot]  <= got_nxt;
      if (rel_valid) got_q[rel_slot]  <= '0;
    end
  end

  // R5
  no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (got_q[rsp_slot] < need_q[rsp_slot]));
endmodule

// File: rtl/sbm_fwd_queue.sv
module sbm_fwd_queue #(
  parameter int DEPTH = 32,
  parameter int W     = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] head
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;

  assign valid = (count != '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)) || pop);

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !pop |=> valid && $stable(head));
endmodule

// File: rtl/sbm_pkt_ram.sv
module sbm_pkt_ram #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 288,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbm_top.sv
module sbm_top #(
  parameter int NUM_REQ  = 4,
  parameter int NUM_PS   = 16,
  parameter int NUM_NS   = 16,
  parameter int DATA_W   = 128,
  parameter int MAX_LEN  = 256,
  parameter int NP_BEATS = 2,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int PAY_BEATS  = MAX_LEN / BEAT_BYTES,
  localparam int NUM_SLOTS  = NUM_PS + NUM_NS,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int REQ_W      = $clog2(NUM_REQ),
  localparam int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int BCNT_W     = $clog2(PAY_BEATS + 1),
  localparam int BEAT_W     = $clog2(PAY_BEATS),
  localparam int MEM_DEPTH  = NUM_PS * PAY_BEATS + NUM_NS * NP_BEATS,
  localparam int ADDR_W     = $clog2(MEM_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ-1:0]       req_nopay,
  input  logic [NUM_REQ*LEN_W-1:0] req_len,
  output logic                     gnt_valid,
  output logic [REQ_W-1:0]         gnt_req,
  output logic [SLOT_W-1:0]        gnt_slot,
  input  logic                     rsp_valid,
  input  logic [SLOT_W-1:0]        rsp_slot,
  input  logic [DATA_W-1:0]        rsp_data,
  output logic                     fwd_valid,
  output logic [SLOT_W-1:0]        fwd_slot,
  output logic [BCNT_W-1:0]        fwd_beats,
  input  logic                     fwd_ready,
  input  logic                     rd_en,
  input  logic [SLOT_W-1:0]        rd_slot,
  input  logic [BEAT_W-1:0]        rd_beat,
  output logic [DATA_W-1:0]        rd_data
);
  logic              set_valid, wr_en, done_valid, q_filled, rel_valid;
  logic [SLOT_W-1:0] set_slot, done_slot;
  logic [BCNT_W-1:0] set_beats;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign rel_valid = fwd_valid && fwd_ready;
  assign rd_addr   = ADDR_W'(sbm_pkg::slot_base(int'(rd_slot), NUM_PS, PAY_BEATS, NP_BEATS)
                             + int'(rd_beat));

  sbm_slot_alloc #(
    .NUM_REQ(NUM_REQ), .NUM_PS(NUM_PS), .NUM_NS(NUM_NS), .LEN_W(LEN_W),
    .BEAT_BYTES(BEAT_BYTES), .NP_BEATS(NP_BEATS), .BCNT_W(BCNT_W)
  ) u_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_nopay(req_nopay), .req_len(req_len),
    .rel_valid(rel_valid), .rel_slot(fwd_slot),
    .set_valid(set_valid), .set_slot(set_slot), .set_beats(set_beats),
    .gnt_valid(gnt_valid), .gnt_req(gnt_req), .gnt_slot(gnt_slot)
  );

  sbm_fill_track #(
    .NUM_PS(NUM_PS), .NUM_NS(NUM_NS), .PAY_BEATS(PAY_BEATS), .NP_BEATS(NP_BEATS),
    .BCNT_W(BCNT_W), .ADDR_W(ADDR_W)
  ) u_fill (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_slot(set_slot), .set_beats(set_beats),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rel_valid(rel_valid), .rel_slot(fwd_slot),
    .q_slot(fwd_slot), .wr_en(wr_en), .wr_addr(wr_addr), .done_valid(done_valid),
    .done_slot(done_slot), .q_filled(q_filled), .q_beats(fwd_beats)
  );

  sbm_fwd_queue #(.DEPTH(NUM_SLOTS), .W(SLOT_W)) u_fwdq (
    .clk(clk), .rst(rst), .push(done_valid), .push_data(done_slot),
    .pop(rel_valid), .valid(fwd_valid), .head(fwd_slot)
  );

  sbm_pkt_ram #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(rsp_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  // R5
  fwd_filled_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> q_filled);
endmodule

// File: tb/tb_sbm_top.sv
`timescale 1ns/1ps
module tb_sbm_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]   req_valid = '0, req_nopay = '0;
  logic [35:0]  req_len = '0;
  logic         gnt_valid;
  logic [1:0]   gnt_req;
  logic [4:0]   gnt_slot;
  logic         rsp_valid = 1'b0;
  logic [4:0]   rsp_slot = '0;
  logic [127:0] rsp_data = '0;
  logic         fwd_valid, fwd_ready = 1'b0;
  logic [4:0]   fwd_slot, fwd_beats;
  logic         rd_en = 1'b0;
  logic [4:0]   rd_slot = '0;
  logic [3:0]   rd_beat = '0;
  logic [127:0] rd_data;

  sbm_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_nopay(req_nopay), .req_len(req_len),
    .gnt_valid(gnt_valid), .gnt_req(gnt_req), .gnt_slot(gnt_slot),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_slot(fwd_slot), .fwd_beats(fwd_beats), .fwd_ready(fwd_ready),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_beat(rd_beat), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;
  bit busy [32];
  int need [32];
  int got  [32];
  int q[$];
  int fill[$];
  logic [127:0] mm [int];
  int rr = 3;
  bit lgv = 0;
  int lgr = 0;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int waddr(int s, int b);
    return (s < 16) ? s * 16 + b : 256 + (s - 16) * 2 + b;
  endfunction

  function automatic int lowest_free(bit np);
    for (int s = (np ? 16 : 0); s < (np ? 32 : 16); s++) if (!busy[s]) return s;
    return -1;
  endfunction

  function automatic int beats_for(bit np, int len);
    return np ? 2 : (len + 15) / 16;
  endfunction

  task automatic step();
    bit eg = 0; int ew = 0; int es = 0; int el = 0;
    bit pv; int ph; bit pop; bit rdv; logic [127:0] erd = '0;
    for (int k = 1; k <= 4; k++) begin
      if (!eg && req_valid[(rr + k) % 4] && !(lgv && lgr == (rr + k) % 4) &&
          lowest_free(req_nopay[(rr + k) % 4]) >= 0) begin
        eg = 1; ew = (rr + k) % 4;
      end
    end
    if (eg) begin
      es = lowest_free(req_nopay[ew]);
      el = beats_for(req_nopay[ew], int'(req_len[ew*9 +: 9]));
    end
    pv  = q.size() > 0;
    ph  = pv ? q[0] : 0;
    pop = pv && fwd_ready;
    rdv = rd_en;
    if (rd_en && mm.exists(waddr(int'(rd_slot), int'(rd_beat))))
      erd = mm[waddr(int'(rd_slot), int'(rd_beat))];
    @(posedge clk); #1;
    if (pop) begin busy[ph] = 0; got[ph] = 0; void'(q.pop_front()); end
    if (rsp_valid) begin
      mm[waddr(int'(rsp_slot), got[rsp_slot])] = rsp_data;
      got[rsp_slot]++;
      if (got[rsp_slot] == need[rsp_slot]) q.push_back(int'(rsp_slot));
    end
    if (eg) begin busy[es] = 1; need[es] = el; rr = ew; end
    lgv = eg; lgr = ew;
    chk(gnt_valid == eg, "R3/R4 gnt_valid", 128'(gnt_valid), 128'(eg));
    if (eg && gnt_valid) begin
      chk(int'(gnt_req) == ew, "R3 round-robin gnt_req", 128'(gnt_req), 128'(ew));
      chk(int'(gnt_slot) == es, "R2 gnt_slot", 128'(gnt_slot), 128'(es));
    end
    chk(fwd_valid == (q.size() > 0), "R5/R7 fwd_valid", 128'(fwd_valid), 128'(q.size() > 0));
    if (q.size() > 0 && fwd_valid) begin
      chk(int'(fwd_slot) == q[0], "R7 fwd_slot order", 128'(fwd_slot), 128'(q[0]));
      chk(int'(fwd_beats) == need[q[0]], "R5 fwd_beats", 128'(fwd_beats), 128'(need[q[0]]));
    end
    if (rdv) chk(rd_data == erd, "R6/R9 rd_data", rd_data, erd);
    if (gnt_valid) begin
      req_valid[gnt_req] = 1'b0;
      fill.push_back(int'(gnt_slot));
    end
  endtask

  task automatic ask(int r, bit np, int len);
    req_valid[r] = 1'b1;
    req_nopay[r] = np;
    req_len[r*9 +: 9] = 9'(len);
  endtask

  task automatic beat(int j);
    int s = fill[j];
    rsp_valid = 1'b1;
    rsp_slot  = 5'(s);
    rsp_data  = {$urandom(), $urandom(), $urandom(), $urandom()};
    if (got[s] + 1 == need[s]) fill.delete(j);
    step();
    rsp_valid = 1'b0;
  endtask

  task automatic read_head();
    rd_en = 1'b0;
    if (q.size() > 0 && $urandom_range(0, 1) == 1) begin
      rd_en   = 1'b1;
      rd_slot = 5'(q[0]);
      rd_beat = 4'($urandom_range(0, need[q[0]] - 1));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(gnt_valid == 1'b0, "R1 gnt_valid in reset", 128'(gnt_valid), 128'(0));
    chk(fwd_valid == 1'b0, "R1 fwd_valid in reset", 128'(fwd_valid), 128'(0));
    rst = 1'b0;
    step();
    chk(gnt_valid == 1'b0, "R1 no grant after reset", 128'(gnt_valid), 128'(0));

    // R2 R3 first grant goes to requester 0, slot 0
    ask(0, 0, 17);
    step();
    chk(gnt_slot == 5'd0 && gnt_req == 2'd0, "R2 first payload slot", 128'(gnt_slot), 128'(0));

    // R3 round-robin among all four
    ask(0, 0, 32); ask(1, 0, 1); ask(2, 0, 256); ask(3, 0, 100);
    begin
      int order[4];
      for (int n = 0; n < 4; n++) begin step(); order[n] = int'(gnt_req); end
      chk(order[0] == 1 && order[1] == 2 && order[2] == 3 && order[3] == 0,
          "R3 rotation 1,2,3,0", 128'(order[0]), 128'(1));
    end

    // R5 R6 interleaved fill, one beat per slot in turn
    fwd_ready = 1'b0;
    while (fill.size() > 0) begin
      for (int j = fill.size() - 1; j >= 0; j--) beat(j);
    end
    // R9 read back every beat of each completed slot, then drain (R8)
    for (int p = 0; p < 5; p++) begin
      for (int b = 0; b < need[q[0]]; b++) begin
        rd_en = 1'b1; rd_slot = 5'(q[0]); rd_beat = 4'(b);
        step();
      end
      rd_en = 1'b0;
      fwd_ready = 1'b1;
      step();
      fwd_ready = 1'b0;
    end

    // R4 exhaust no-payload pool
    for (int n = 0; n < 16; n++) begin ask(1, 1, 0); step(); step(); end
    chk(busy[31] && gnt_slot == 5'd31, "R1/R2 last no-payload slot", 128'(gnt_slot), 128'(31));
    ask(1, 1, 0);
    ask(2, 0, 48);
    step();
    chk(gnt_valid && gnt_req == 2'd2, "R4 other class served", 128'(gnt_req), 128'(2));
    repeat (3) step();
    chk(gnt_valid == 1'b0 && req_valid[1], "R4 pending while pool empty", 128'(gnt_valid), 128'(0));
    // fill slot 16 and release it while requester 1 still waits
    for (int j = 0; j < fill.size(); j++)
      if (fill[j] == 16) begin beat(j); break; end
    for (int j = 0; j < fill.size(); j++)
      if (fill[j] == 16) begin beat(j); break; end
    fwd_ready = 1'b1;
    step();
    chk(gnt_valid == 1'b0, "R8 no grant at release edge", 128'(gnt_valid), 128'(0));
    fwd_ready = 1'b0;
    step();
    chk(gnt_valid && gnt_slot == 5'd16, "R8 freed slot regranted", 128'(gnt_slot), 128'(16));

    // random phase: interleaved beats, random ready and reads
    for (int c = 0; c < 4000; c++) begin
      for (int r = 0; r < 4; r++)
        if (!req_valid[r] && $urandom_range(0, 3) == 0)
          ask(r, $urandom_range(0, 3) == 0, $urandom_range(1, 256));
      fwd_ready = $urandom_range(0, 2) != 0;
      read_head();
      if (fill.size() > 0 && $urandom_range(0, 3) != 0) beat($urandom_range(0, fill.size() - 1));
      else step();
    end
    // drain
    req_valid = '0;
    for (int c = 0; c < 3000 && (fill.size() > 0 || q.size() > 0); c++) begin
      fwd_ready = 1'b1;
      read_head();
      if (fill.size() > 0) beat($urandom_range(0, fill.size() - 1));
      else step();
    end
    rd_en = 1'b0;
    step();
    chk(fwd_valid == 1'b0, "R8 queue empty after drain", 128'(fwd_valid), 128'(0));
    begin
      int nb = 0;
      foreach (busy[s]) nb += busy[s];
      chk(nb == 0, "R8 every slot released", 128'(nb), 128'(0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule